// File: doc/BRIEF.md
# Boot-Sector Write Protection Guard

This block sits between a flash command decoder and the array sequencer. It judges each write-type request against a 4 MiB array that has 68 sectors of mixed size. A small boot cluster of 4 KB, 4 KB, 8 KB, 16 KB and 32 KB sectors sits at one end of the array. The other 63 sectors are 64 KB each. A strap input places the cluster at the low end (bottom boot) or mirrors it to the high end (top boot).

For any address, the block reports the index, base and byte size of the sector that holds it. This lookup is combinational. A 3-bit protect code selects a protected region that grows from the boot end of the array: 4 KB, 8 KB, 16 KB, 32 KB, 64 KB, then half of the array, then all of it.

When a request strobe arrives, the block registers a single allow/reject verdict for the request. The request can be a page program, a sector erase, a chip erase or a write to the protect register. The verdict appears on the next clock edge.

Top module: `bootsec_wr_guard`

## Requirements
- R1: With `top_boot`=0, addresses 000000h-000FFFh, 001000h-001FFFh, 002000h-003FFFh, 004000h-007FFFh and 008000h-00FFFFh fall in sectors 0 to 4 of 4, 4, 8, 16 and 32 KB. Each 64 KB block from 010000h upward is one sector, numbered 5 to 67 in address order.
- R2: With `top_boot`=1, the layout is mirrored. Sector 67 is 4 KB at 3FF000h, sector 66 is 4 KB at 3FE000h, sector 65 is 8 KB at 3FC000h, sector 64 is 16 KB at 3F8000h and sector 63 is 32 KB at 3F0000h. Sectors 0 to 62 are 64 KB each, ascending from 000000h.
- R3: `sect_base` and `sect_bytes` follow `req_addr` and `top_boot` without a clock. `sect_bytes` is a power of two, `sect_base` is a multiple of it, and the address lies inside [`sect_base`, `sect_base`+`sect_bytes`).
- R4: With `top_boot`=0, a `bp_code` of 1, 2, 3, 4, 5, 6 or 7 protects the addresses from 0 up to 4 KB, 8 KB, 16 KB, 32 KB, 64 KB, 2048 KB or the whole array. Code 0 protects nothing.
- R5: With `top_boot`=1, each code protects the same amount of memory, measured downward from 3FFFFFh. Code 6 covers 200000h-3FFFFFh.
- R6: A page program (`req_kind`=00) or a sector erase (`req_kind`=01) is rejected when the sector that holds `req_addr` overlaps the protected region. Otherwise it is allowed. `prot_lock` and `guard_n` have no effect on these two kinds.
- R7: A chip erase (`req_kind`=10) is allowed only when `bp_code` is 000.
- R8: A protect-register write (`req_kind`=11) is rejected when `prot_lock`=1 and `guard_n`=0. It is allowed in the other three combinations.
- R9: `resp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. `resp_allow` carries the verdict for that request, and back-to-back requests each get their own verdict.
- R10: A synchronous reset clears `resp_valid` and `resp_allow` to 0, including any verdict that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 2 | 00 page program, 01 sector erase, 10 chip erase, 11 protect-register write |
| req_addr | input | 22 | Byte address of the request |
| bp_code | input | 3 | Current block-protect code |
| top_boot | input | 1 | Layout strap: 1 places the boot cluster at the top |
| prot_lock | input | 1 | Protect-register lock bit |
| guard_n | input | 1 | Active-low write-protect pin |
| resp_valid | output | 1 | Verdict valid, one cycle after the request |
| resp_allow | output | 1 | 1 = request allowed, 0 = rejected |
| sect_idx | output | 7 | Sector index for req_addr |
| sect_base | output | 22 | First byte address of that sector |
| sect_bytes | output | 22 | Size of that sector in bytes |

## Verification
The hardest cases to reach are the exact boundaries in the top-boot layout. There the protected region and the mirrored sectors meet at addresses counted down from the end of the array. An off-by-one mistake in the mirroring would show only at one address on either side of the boundary. The vector table therefore puts a top-boot request on each side of every code boundary: 3FF800h against 3FEFFFh, 3F8000h against 3F0000h, and 200000h against 1FFFFFh under code 6. Each of these is paired with the expected sector base, so a wrong mirror and a wrong range each show up separately. Back-to-back strobes and a reset that lands on a pending verdict are driven as directed cases.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

    // Array geometry
    localparam int ADDR_W     = 22;  // byte address width (4 MiB)
    localparam int BIG_LOG2   = 16;  // uniform sector size, log2
    localparam int SMALL_LOG2 = 12;  // smallest boot sector, log2
    localparam int BP_W       = 3;   // protect code width

    // Derived geometry
    localparam int BOOT_N = BIG_LOG2 - SMALL_LOG2 + 1;          // 5 boot sectors
    localparam int BIG_N  = (1 << (ADDR_W - BIG_LOG2)) - 1;     // 63 uniform sectors
    localparam int SECT_N = BOOT_N + BIG_N;                     // 68 sectors
    localparam int IDX_W  = $clog2(SECT_N);                     // 7
    localparam int HI_W   = ADDR_W - BIG_LOG2;                  // 6
    localparam int SPAN_W = ADDR_W + 1;                         // covers the full array size

    typedef enum logic [1:0] {
        KIND_PROG  = 2'b00,
        KIND_SERASE = 2'b01,
        KIND_CERASE = 2'b10,
        KIND_PWRITE = 2'b11
    } req_kind_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] bytes;
    } sect_info_t;

    // Size of the protected region for a code, in bytes
    function automatic logic [SPAN_W-1:0] prot_span(input logic [BP_W-1:0] code);
        logic [SPAN_W-1:0] s;
        unique case (code)
            3'd0:    s = '0;
            3'd6:    s = SPAN_W'(1) << (ADDR_W - 1);
            3'd7:    s = SPAN_W'(1) << ADDR_W;
            default: s = SPAN_W'(1) << (SMALL_LOG2 - 1 + int'(code));
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bsg_sector_lookup.sv
module bsg_sector_lookup
    import bsg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              top_boot,
    output sect_info_t        phys,
    output logic [ADDR_W-1:0] mir_base
);

    // Work in the bottom-boot frame: a top-boot address is mirrored first
    logic [ADDR_W-1:0] m_addr;
    logic [HI_W-1:0]   m_hi;
    sect_info_t        m_info;
    logic [ADDR_W-1:0] m_last;

    assign m_addr = top_boot ? ~addr : addr;
    assign m_hi   = m_addr[ADDR_W-1:BIG_LOG2];

    always_comb begin
        m_info.idx   = '0;
        m_info.base  = '0;
        m_info.bytes = ADDR_W'(1) << SMALL_LOG2;
        if (m_hi != '0) begin
            m_info.idx   = IDX_W'(BOOT_N - 1) + IDX_W'(m_hi);
            m_info.base  = {m_hi, {BIG_LOG2{1'b0}}};
            m_info.bytes = ADDR_W'(1) << BIG_LOG2;
        end else begin
            // highest set bit in the boot window picks the boot sector
            for (int k = SMALL_LOG2; k < BIG_LOG2; k++) begin
                if (m_addr[k]) begin
                    m_info.idx   = IDX_W'(k - SMALL_LOG2 + 1);
                    m_info.base  = ADDR_W'(1) << k;
                    m_info.bytes = ADDR_W'(1) << k;
                end
            end
        end
    end

    assign m_last   = m_info.base + m_info.bytes - ADDR_W'(1);
    assign mir_base = m_info.base;

    always_comb begin
        phys.bytes = m_info.bytes;
        if (top_boot) begin
            phys.idx  = IDX_W'(SECT_N - 1) - m_info.idx;
            phys.base = ~m_last;
        end else begin
            phys.idx  = m_info.idx;
            phys.base = m_info.base;
        end
    end

endmodule

// File: rtl/bsg_prot_decode.sv
module bsg_prot_decode
    import bsg_pkg::*;
(
    input  logic [BP_W-1:0]   bp_code,
    output logic [SPAN_W-1:0] span
);

    assign span = prot_span(bp_code);

endmodule

// File: rtl/bsg_verdict.sv
module bsg_verdict
    import bsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [BP_W-1:0]   bp_code,
    input  logic [ADDR_W-1:0] mir_base,
    input  logic [SPAN_W-1:0] span,
    input  logic              prot_lock,
    input  logic              guard_n,
    output logic              resp_valid,
    output logic              resp_allow
);

    req_kind_e kind;
    logic      hit;
    logic      allow_d;

    assign kind = req_kind_e'(req_kind);
    // The mirrored base sits in the frame where protection grows from 0
    assign hit  = {1'b0, mir_base} < span;

    always_comb begin
        unique case (kind)
            KIND_PROG, KIND_SERASE: allow_d = !hit;
            KIND_CERASE:            allow_d = (bp_code == '0);
            KIND_PWRITE:            allow_d = !(prot_lock && !guard_n);
            default:                allow_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_allow <= req_valid && allow_d;
        end
    end

    assert_resp_timing_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    assert_resp_cause_R9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(req_valid));

    assert_chip_erase_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && $past(req_kind) == KIND_CERASE && $past(bp_code) != '0) |-> !resp_allow);

    assert_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && $past(req_kind) == KIND_PWRITE && $past(prot_lock) && !$past(guard_n))
            |-> !resp_allow);

    assert_region_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !$past(req_kind[1]) && $past(hit)) |-> !resp_allow);

endmodule

// File: rtl/bootsec_wr_guard.sv
module bootsec_wr_guard
    import bsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BP_W-1:0]   bp_code,
    input  logic              top_boot,
    input  logic              prot_lock,
    input  logic              guard_n,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic [IDX_W-1:0]  sect_idx,
    output logic [ADDR_W-1:0] sect_base,
    output logic [ADDR_W-1:0] sect_bytes
);

    sect_info_t        phys;
    logic [ADDR_W-1:0] mir_base;
    logic [SPAN_W-1:0] span;

    bsg_sector_lookup u_lookup (
        .addr     (req_addr),
        .top_boot (top_boot),
        .phys     (phys),
        .mir_base (mir_base)
    );

    bsg_prot_decode u_decode (
        .bp_code (bp_code),
        .span    (span)
    );

    bsg_verdict u_verdict (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .bp_code    (bp_code),
        .mir_base   (mir_base),
        .span       (span),
        .prot_lock  (prot_lock),
        .guard_n    (guard_n),
        .resp_valid (resp_valid),
        .resp_allow (resp_allow)
    );

    assign sect_idx   = phys.idx;
    assign sect_base  = phys.base;
    assign sect_bytes = phys.bytes;

    assert_pow2_size_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(sect_bytes) == 1);

    assert_contains_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (req_addr >= sect_base) && ((req_addr - sect_base) < sect_bytes));

    assert_index_range_R1: assert property (@(posedge clk) disable iff (rst)
        sect_idx < IDX_W'(SECT_N));

    assert_reset_clear_R10: assert property (@(posedge clk)
        $past(rst) |-> (!resp_valid && !resp_allow));

endmodule

// File: tb/bootsec_wr_guard_tb.sv
module bootsec_wr_guard_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [21:0] req_addr;
    logic [2:0]  bp_code;
    logic        top_boot;
    logic        prot_lock;
    logic        guard_n;
    logic        resp_valid;
    logic        resp_allow;
    logic [6:0]  sect_idx;
    logic [21:0] sect_base;
    logic [21:0] sect_bytes;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bootsec_wr_guard u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .bp_code(bp_code), .top_boot(top_boot),
        .prot_lock(prot_lock), .guard_n(guard_n), .resp_valid(resp_valid),
        .resp_allow(resp_allow), .sect_idx(sect_idx), .sect_base(sect_base),
        .sect_bytes(sect_bytes)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [21:0] addr;
        logic [2:0]  bp;
        logic        top;
        logic        lock;
        logic        gn;
        logic        allow;
        logic [6:0]  idx;
        logic [21:0] base;
        logic [21:0] bytes;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 22'h000000, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 7'd0,  22'h000000, 22'h001000},
        '{2'd0, 22'h001800, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 7'd1,  22'h001000, 22'h001000},
        '{2'd1, 22'h001000, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 7'd1,  22'h001000, 22'h001000},
        '{2'd1, 22'h003FFF, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 7'd2,  22'h002000, 22'h002000},
        '{2'd0, 22'h004000, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 7'd3,  22'h004000, 22'h004000},
        '{2'd1, 22'h00A000, 3'd5, 1'b0, 1'b0, 1'b1, 1'b0, 7'd4,  22'h008000, 22'h008000},
        '{2'd1, 22'h010000, 3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 7'd5,  22'h010000, 22'h010000},
        '{2'd0, 22'h1FFFFF, 3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 7'd35, 22'h1F0000, 22'h010000},
        '{2'd0, 22'h200000, 3'd6, 1'b0, 1'b0, 1'b1, 1'b1, 7'd36, 22'h200000, 22'h010000},
        '{2'd0, 22'h3FFFFF, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0, 7'd67, 22'h3F0000, 22'h010000},
        '{2'd2, 22'h000000, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 7'd0,  22'h000000, 22'h001000},
        '{2'd2, 22'h3FF000, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 7'd67, 22'h3FF000, 22'h001000},
        '{2'd0, 22'h3FF800, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 7'd67, 22'h3FF000, 22'h001000},
        '{2'd0, 22'h3FEFFF, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 7'd66, 22'h3FE000, 22'h001000},
        '{2'd1, 22'h3FC000, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 7'd65, 22'h3FC000, 22'h002000},
        '{2'd1, 22'h3F8000, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 7'd64, 22'h3F8000, 22'h004000},
        '{2'd1, 22'h3F0000, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 7'd63, 22'h3F0000, 22'h008000},
        '{2'd0, 22'h200000, 3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 7'd32, 22'h200000, 22'h010000},
        '{2'd0, 22'h1FFFFF, 3'd6, 1'b1, 1'b0, 1'b1, 1'b1, 7'd31, 22'h1F0000, 22'h010000},
        '{2'd0, 22'h000000, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 7'd0,  22'h000000, 22'h010000},
        '{2'd3, 22'h000000, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 7'd0,  22'h000000, 22'h001000},
        '{2'd3, 22'h000000, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 7'd0,  22'h000000, 22'h001000},
        '{2'd3, 22'h000000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 7'd0,  22'h000000, 22'h001000},
        '{2'd2, 22'h000000, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 7'd0,  22'h000000, 22'h010000},
        '{2'd0, 22'h010000, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 7'd5,  22'h010000, 22'h010000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] k, input logic [21:0] a, input logic [2:0] bp,
                         input logic top, input logic lk, input logic gn);
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = a;
        bp_code   = bp;
        top_boot  = top;
        prot_lock = lk;
        guard_n   = gn;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0;
        bp_code = '0; top_boot = 1'b0; prot_lock = 1'b0; guard_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset resp_valid", 32'(resp_valid), 32'd0);
        check("R10 reset resp_allow", 32'(resp_allow), 32'd0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            @(negedge clk);
            drive(VECS[i].kind, VECS[i].addr, VECS[i].bp, VECS[i].top, VECS[i].lock, VECS[i].gn);
            #1;
            check(VECS[i].top ? "R2 sect_idx" : "R1 sect_idx", 32'(sect_idx), 32'(VECS[i].idx));
            check("R3 sect_base", 32'(sect_base), 32'(VECS[i].base));
            check("R3 sect_bytes", 32'(sect_bytes), 32'(VECS[i].bytes));
            @(negedge clk);
            req_valid = 1'b0;
            check("R9 resp_valid", 32'(resp_valid), 32'd1);
            if (VECS[i].kind == 2'd2)      tag = "R7 chip erase verdict";
            else if (VECS[i].kind == 2'd3) tag = "R8 protect write verdict";
            else if (VECS[i].top)          tag = "R5/R6 region verdict";
            else                           tag = "R4/R6 region verdict";
            check(tag, 32'(resp_allow), 32'(VECS[i].allow));
        end

        // R9: idle cycles give no response
        @(negedge clk);
        check("R9 idle resp_valid", 32'(resp_valid), 32'd0);

        // R9: back-to-back requests, each with its own verdict
        @(negedge clk);
        drive(2'd2, 22'h000000, 3'd1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R9 b2b first valid", 32'(resp_valid), 32'd1);
        check("R9 b2b first deny", 32'(resp_allow), 32'd0);
        drive(2'd2, 22'h000000, 3'd0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 b2b second valid", 32'(resp_valid), 32'd1);
        check("R9 b2b second allow", 32'(resp_allow), 32'd1);
        @(negedge clk);
        check("R9 b2b drained", 32'(resp_valid), 32'd0);

        // R10: reset while a verdict is pending
        drive(2'd0, 22'h200000, 3'd0, 1'b0, 1'b0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 pending cleared valid", 32'(resp_valid), 32'd0);
        check("R10 pending cleared allow", 32'(resp_allow), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 after reset", 32'(resp_valid), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule